// File: doc/BRIEF.md
# Quad Special-Wakeup Register Controller

This block is a 64-bit register target serving a group of four cores. Software raises or drops a special-wakeup request per core by writing to a request register. The cores it affects are chosen by a one-hot nibble carried in the register address, not in the data. The same write also updates one shared completion flag. A status register reports that flag. The four per-core wakeup flags leave the block as plain level outputs. Sequencing the cores' power states is handled elsewhere.

Requests arrive on a valid/ready channel: one beat carries the address, direction, access size and write data. Every accepted request produces exactly one response beat on a valid/ready channel, carrying read data and an unimplemented-access indication. The block holds one response. A new request is accepted only when that slot is empty, or is being emptied in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A response that is not taken stays stable until it is taken. Bit numbers in this brief are little-endian, with bit 63 the MSB of the data word.

Top module: `swk_quad_ctrl`

## Requirements
- R1: After reset all wakeup outputs are 0, the done flag is 0 (a status read returns zero), and no response is pending.
- R2: A register offset is the byte address shifted right by 3, and byte address bits [2:0] must be zero. Offset bits [15:12] (byte address bits [18:15]) are the core-select nibble and are ignored by decode. The request register is offset 0x83C and the status register is offset 0x82C.
- R3: On a write to the request register, data bit 63 is stored into the wakeup flag of each selected core. Core i is selected by offset bit 15-i (byte address bit 18-i). The flags of unselected cores keep their value.
- R4: Every write to the request register loads data bit 63 into the done flag, whatever the select nibble is, including an empty one.
- R5: A status read returns 0, except that bits 62 and 59 are both 1 while the done flag is 1. The response has the unimplemented indication low.
- R6: Any other access is unrecognised. This includes a read of the request register, a write of the status register and a misaligned address. It raises the unimplemented indication and changes no state. An unrecognised read returns all ones and an unrecognised write returns zero.
- R7: An access whose size field is not 8 bytes is treated as unrecognised (as in R6), even at a valid offset.
- R8: Each accepted request yields one response, valid in the cycle after acceptance. The wakeup outputs change on the same edge that accepts the write.
- R9: While a response is pending and not taken, req_ready is low and the response data and indication stay stable. A request presented in that time is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (32) | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | 64 | Read data (zero for writes) |
| rsp_unimp | output | 1 | Access was unrecognised or had an invalid size |
| wake_o | output | NUM_CORES (4) | Per-core special-wakeup flags |

## Verification
The request register is written with every one of the sixteen select nibbles, once with data bit 63 set and once with it clear. After each write the flags are compared with a bench model, so a wrong or reversed select bit or a leak into an unselected core shows up. A status read after each write separates a correct done flag from one that ignores empty selections. Every access size is swept at the request offset, which catches a loose size check. Reads of the request register, writes of status, misaligned and foreign offsets prove the unimplemented path leaves state untouched. A held-off response with a second request waiting checks back-pressure and that the waiting request is taken exactly when the slot frees.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned WORD_SHIFT = 3;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned SEL_LO     = 12;
  localparam int unsigned SEL_W      = 4;
  localparam logic [31:0] OFS_WAKE_REQ = 32'h0000_083C;
  localparam logic [31:0] OFS_STATUS   = 32'h0000_082C;
  localparam int unsigned VAL_BIT   = DATA_W - 1;
  localparam int unsigned DONE_BIT_A = DATA_W - 2;
  localparam int unsigned DONE_BIT_B = DATA_W - 5;

  typedef enum logic [1:0] {
    ACC_MISS    = 2'd0,
    ACC_REQ_WR  = 2'd1,
    ACC_STAT_RD = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/swk_decode.sv
module swk_decode
  import swk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 write,
  input  logic [3:0]           size,
  output acc_kind_e            kind,
  output logic [NUM_CORES-1:0] sel
);
  localparam int unsigned OFS_W = ADDR_W - WORD_SHIFT;
  localparam int unsigned SEL_HI = SEL_LO + SEL_W - 1;

  logic [OFS_W-1:0] offset;
  logic [OFS_W-1:0] sel_mask;
  logic [OFS_W-1:0] masked;
  logic             aligned;
  logic             size_ok;

  assign offset  = addr[ADDR_W-1:WORD_SHIFT];
  assign aligned = (addr[WORD_SHIFT-1:0] == '0);
  assign size_ok = (size == 4'(WORD_BYTES));

  always_comb begin
    sel_mask = '0;
    sel_mask[SEL_HI:SEL_LO] = '1;
  end
  assign masked = offset & ~sel_mask;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_sel
    assign sel[i] = offset[SEL_HI - i];
  end

  always_comb begin
    kind = ACC_MISS;
    if (aligned && size_ok) begin
      if (write && masked == OFS_W'(OFS_WAKE_REQ))
        kind = ACC_REQ_WR;
      else if (!write && masked == OFS_W'(OFS_STATUS))
        kind = ACC_STAT_RD;
    end
  end

  initial begin
    assert (NUM_CORES >= 1 && NUM_CORES <= SEL_W)
      else $error("NUM_CORES out of range");
  end
endmodule

// File: rtl/swk_flags.sv
module swk_flags
  import swk_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_CORES-1:0] sel,
  input  logic                 val,
  output logic [NUM_CORES-1:0] wake,
  output logic                 done
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n)                wake[i] <= 1'b0;
      else if (wr_en && sel[i])  wake[i] <= val;
    end

    // R3: an unselected core keeps its flag across a request write
    p_unsel_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel[i]) |=> $stable(wake[i]));
    // R3: a selected core takes the written value
    p_sel_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[i]) |=> (wake[i] == $past(val)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     done <= 1'b0;
    else if (wr_en) done <= val;
  end

  // R4: done follows every request write
  p_done_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done == $past(val)));
  // R6: no request write, no state change
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(wake) && $stable(done)));
endmodule

// File: rtl/swk_resp.sv
module swk_resp
  import swk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  acc_kind_e         kind,
  input  logic              done,
  output logic              req_ready,
  output logic              accept,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_unimp
);
  logic [DATA_W-1:0] rdata_d;
  logic              rsp_is_read;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    rdata_d = '0;
    if (kind == ACC_STAT_RD) begin
      rdata_d[DONE_BIT_A] = done;
      rdata_d[DONE_BIT_B] = done;
    end else if (kind == ACC_MISS && !req_write) begin
      rdata_d = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_unimp   <= 1'b0;
      rsp_is_read <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_rdata   <= rdata_d;
      rsp_unimp   <= (kind == ACC_MISS);
      rsp_is_read <= !req_write;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  // R8: a response follows every accepted request
  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  // R9: a held response stays stable
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_unimp)));
  // R6: unrecognised read returns all ones
  p_miss_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unimp && rsp_is_read) |-> (rsp_rdata == '1));
  // R5: a recognised read carries only the two done bits
  p_stat_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_unimp && rsp_is_read) |->
      (rsp_rdata[DONE_BIT_A] == rsp_rdata[DONE_BIT_B] &&
       $countones(rsp_rdata) <= 2));
endmodule

// File: rtl/swk_quad_ctrl.sv
module swk_quad_ctrl
  import swk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [3:0]           req_size,
  input  logic [63:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [63:0]          rsp_rdata,
  output logic                 rsp_unimp,
  output logic [NUM_CORES-1:0] wake_o
);
  acc_kind_e            kind;
  logic [NUM_CORES-1:0] sel;
  logic                 accept;
  logic                 done;
  logic                 wr_en;

  swk_decode #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES)) u_decode (
    .addr (req_addr),
    .write(req_write),
    .size (req_size),
    .kind (kind),
    .sel  (sel)
  );

  assign wr_en = accept && (kind == ACC_REQ_WR);

  swk_flags #(.NUM_CORES(NUM_CORES)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .sel  (sel),
    .val  (req_wdata[VAL_BIT]),
    .wake (wake_o),
    .done (done)
  );

  swk_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .kind     (kind),
    .done     (done),
    .req_ready(req_ready),
    .accept   (accept),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .rsp_unimp(rsp_unimp)
  );

  // R9: no acceptance while a response is held
  p_no_accept_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/test_swk_quad_ctrl.sv
module test_swk_quad_ctrl;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic        rsp_unimp;
  logic [NC-1:0] wake_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [NC-1:0] m_wake = '0;
  logic          m_done = 1'b0;

  always #2 clk = ~clk;

  swk_quad_ctrl i_swk_quad_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_unimp(rsp_unimp), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input logic [31:0] ofs, input logic [3:0] nib);
    logic [31:0] o;
    o = ofs;
    for (int i = 0; i < NC; i++) o[15 - i] = nib[i];
    return o << 3;
  endfunction

  function automatic logic [63:0] stat_val(input logic d);
    logic [63:0] v;
    v = '0;
    v[62] = d;
    v[59] = d;
    return v;
  endfunction

  // one transaction with rsp_ready high; checks response, flags
  task automatic xact(input string req, input logic wr, input logic [31:0] a,
                      input logic [3:0] sz, input logic [63:0] wd,
                      input logic [63:0] exp_rd, input logic exp_unimp);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " rdata"}, rsp_rdata, exp_rd);
    chk({req, " unimp"}, 64'(rsp_unimp), 64'(exp_unimp));
    chk({req, " wake"}, 64'(wake_o), 64'(m_wake));
  endtask

  task automatic wr_req(input logic [3:0] nib, input logic v);
    for (int i = 0; i < NC; i++) if (nib[i]) m_wake[i] = v;
    m_done = v;
    xact("R3/R4 request write", 1'b1, addr_of(32'h83C, nib), 4'd8,
         {v, 63'h1234_5678_9ABC_DEF}, 64'd0, 1'b0);
  endtask

  task automatic rd_stat(input logic [3:0] nib);
    xact("R5 status read", 1'b0, addr_of(32'h82C, nib), 4'd8, 64'd0,
         stat_val(m_done), 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 wake after reset", 64'(wake_o), 64'd0);
        chk("R1 no response after reset", 64'(rsp_valid), 64'd0);
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        rd_stat(4'h0);

        // R2 R3 R4 R5 R8: sweep every select nibble and value
        for (int v = 0; v < 2; v++)
          for (int n = 0; n < 16; n++) begin
            wr_req(4'(n), v[0]);
            rd_stat(4'(15 - n));
          end
        wr_req(4'hF, 1'b1);
        wr_req(4'h0, 1'b0);
        rd_stat(4'h5);
        wr_req(4'h6, 1'b0);

        // R7 size sweep at the request offset
        for (int s = 0; s < 16; s++)
          if (s != 8)
            xact("R7 bad size write", 1'b1, addr_of(32'h83C, 4'hF), 4'(s),
                 {1'b1, 63'd0}, 64'd0, 1'b1);
        for (int s = 0; s < 16; s++)
          if (s != 8)
            xact("R7 bad size status read", 1'b0, addr_of(32'h82C, 4'h0), 4'(s),
                 64'd0, '1, 1'b1);
        rd_stat(4'h0);

        // R6 unrecognised accesses
        xact("R6 request register read", 1'b0, addr_of(32'h83C, 4'h3), 4'd8,
             64'd0, '1, 1'b1);
        xact("R6 status write", 1'b1, addr_of(32'h82C, 4'hF), 4'd8,
             {1'b1, 63'd0}, 64'd0, 1'b1);
        xact("R6 misaligned write", 1'b1, addr_of(32'h83C, 4'hF) | 32'd4, 4'd8,
             {1'b1, 63'd0}, 64'd0, 1'b1);
        xact("R2 foreign offset write", 1'b1, addr_of(32'h83D, 4'hF), 4'd8,
             {1'b1, 63'd0}, 64'd0, 1'b1);
        xact("R2 high bit offset write", 1'b1, addr_of(32'h1083C, 4'hF), 4'd8,
             {1'b1, 63'd0}, 64'd0, 1'b1);
        xact("R6 foreign offset read", 1'b0, addr_of(32'h100, 4'h0), 4'd8,
             64'd0, '1, 1'b1);
        rd_stat(4'h0);

        // R9 back-pressure
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr_of(32'h82C, 4'h0);
        req_size = 4'd8;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b1; req_addr = addr_of(32'h83C, 4'hF); req_wdata = {1'b1, 63'd0};
        repeat (3) begin
          chk("R9 rsp held valid", 64'(rsp_valid), 64'd1);
          chk("R9 req_ready low", 64'(req_ready), 64'd0);
          chk("R9 rdata stable", rsp_rdata, stat_val(m_done));
          chk("R9 waiting write not taken", 64'(wake_o), 64'(m_wake));
          @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        m_wake = '1; m_done = 1'b1;
        chk("R9 second response after release", 64'(rsp_valid), 64'd1);
        chk("R9 second response is write", rsp_rdata, 64'd0);
        chk("R8 wake updated on accept edge", 64'(wake_o), 64'(m_wake));
        @(negedge clk);
        chk("R8 response drained", 64'(rsp_valid), 64'd0);
        rd_stat(4'h0);

        // R1 reset again clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_wake = '0; m_done = 1'b0;
        chk("R1 wake after second reset", 64'(wake_o), 64'd0);
        rd_stat(4'h0);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule